// File: doc/BRIEF.md
# Text-Mode Character Raster Renderer

This block turns a pixel clock into a complete 640x480, roughly 60 Hz monitor raster and paints it with text cells that are 8 pixels wide and 10 glyph rows tall. As the beam advances, the block works out which cell lies under it and fetches that cell's character code from an external text store. It then fetches the matching glyph byte from an external font store and shifts out the one bit for the current pixel. The result is gated into single-bit red, green and blue lines, which run beside active-low horizontal and vertical sync.

A control byte sets the main video enable, the cursor enable, blink against steady display, and a cursor style: either a whole inverted cell or an inverted bottom glyph row. The same byte carries three colour gates. Two further bytes place the cursor by column and by row. A row-scaling parameter draws each glyph row on one scanline, for 48 text rows, or on two scanlines, for 24 text rows. All raster dimensions are parameters, so a reduced raster can be built for test. The defaults give 80 columns over an 800x525 total raster.

Top module: `txtvga_render`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are red, green and blue low, `hsync_n` and `vsync_n` high and `text_addr` zero. Counting restarts at raster position (0,0) on release.
- R2: `hsync_n` is low for exactly H_SYNC pixel positions per line, starting at horizontal position H_VIS+H_FP. A line is H_VIS+H_FP+H_SYNC+H_BP positions long.
- R3: `vsync_n` is low for exactly V_SYNC whole lines, starting at line V_VIS+V_FP. A frame is V_VIS+V_FP+V_SYNC+V_BP lines.
- R4: At raster position (h,v), `text_addr` equals text row times COLS plus h/8. Text row = v/(FONT_H*ROW_SCALE). The glyph byte is read at `font_addr` = {character code, glyph row[3:0]}, and bit 7-(h mod 8) of it is the pixel. Both stores have a one-clock read latency, and every output shows raster position k exactly 3 clocks after position k is current.
- R5: With ROW_SCALE=2, glyph row = (v/2) mod FONT_H, so each glyph row appears on two consecutive scanlines. With ROW_SCALE=1, glyph row = v mod FONT_H.
- R6: With `ctl` bit 7 clear, red, green and blue stay low while both syncs keep running unchanged.
- R7: `ctl` bit 2 gates red, bit 1 gates green and bit 0 gates blue. A lit pixel drives only the enabled lines.
- R8: With `ctl` bit 6 set and bit 4 clear, every pixel in the cell at (`cur_col`,`cur_row`) is inverted.
- R9: With `ctl` bits 6 and 4 set, only glyph row FONT_H-1 of the cursor cell is inverted.
- R10: With `ctl` bit 5 set, the cursor shows in frames 0-15 after reset, hides in frames 16-31 and then repeats. With bit 5 clear it is steady.
- R11: Outside the visible H_VIS x V_VIS area, red, green and blue are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, one pixel per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl | input | 8 | Bit7 video on, bit6 cursor on, bit5 blink, bit4 underline style, bits2:0 R/G/B gates |
| cur_col | input | 8 | Cursor column |
| cur_row | input | 8 | Cursor text row |
| text_addr | output | 12 | Text store read address |
| text_data | input | 8 | Character code, valid one clock after address |
| font_addr | output | 12 | Font store read address |
| font_data | input | 8 | Glyph byte, bit 7 leftmost, valid one clock after address |
| red | output | 1 | Red pixel |
| green | output | 1 | Green pixel |
| blue | output | 1 | Blue pixel |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |

## Verification
The hardest condition to reach is the blink phase change, because it needs sixteen complete frames before the cursor disappears. At the default raster that is millions of cycles. The bench therefore builds a reduced raster of 4 columns by 2 text rows through the parameters and runs one blink vector for 34 frames. This lets both the shown and hidden phases, and the return to shown, be compared pixel by pixel. Two instances with row scaling of 1 and 2 share the stimulus, so the doubled-scanline case and the underline row of a scaled glyph are checked in the same pass.

// File: rtl/txtvga_pkg.sv
// Shared types for the text raster renderer.
// Assumes glyph rows fit in 4 bits and store addresses are 12 bits.
package txtvga_pkg;
    localparam int ADDR_W = 12;
    localparam int GROW_W = 4;

    // Per-pixel tag carried down the fetch pipeline beside the memory reads.
    typedef struct packed {
        logic              vis;
        logic              hs_n;
        logic              vs_n;
        logic [2:0]        px;
        logic [GROW_W-1:0] grow;
        logic              cur;
    } px_tag_t;

    localparam px_tag_t TAG_IDLE = '{vis: 1'b0, hs_n: 1'b1, vs_n: 1'b1,
                                     px: 3'd0, grow: '0, cur: 1'b0};
endpackage

// File: rtl/txtvga_raster.sv
// Raster position generator: horizontal/vertical counters, sync windows,
// text row / glyph row tracking with scanline repeat, and the frame counter
// that drives cursor blink. Assumes FONT_H <= 16 and ROW_SCALE >= 1.
module txtvga_raster
    import txtvga_pkg::*;
#(
    parameter int COLS      = 80,
    parameter int FONT_H    = 10,
    parameter int ROW_SCALE = 2,
    parameter int H_VIS     = 640,
    parameter int H_FP      = 16,
    parameter int H_SYNC    = 96,
    parameter int H_BP      = 48,
    parameter int V_VIS     = 480,
    parameter int V_FP      = 10,
    parameter int V_SYNC    = 2,
    parameter int V_BP      = 33,
    parameter int BLINK_LOG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              vis,
    output logic              hs_n,
    output logic              vs_n,
    output logic [7:0]        col,
    output logic [2:0]        px,
    output logic [GROW_W-1:0] grow,
    output logic [7:0]        trow,
    output logic [ADDR_W-1:0] row_base,
    output logic              blink_show
);
    localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
    localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
    localparam int HW    = $clog2(H_TOT);
    localparam int VW    = $clog2(V_TOT);
    localparam int SW    = (ROW_SCALE > 1) ? $clog2(ROW_SCALE) : 1;
    localparam logic [HW-1:0] H_LAST  = HW'(H_TOT - 1);
    localparam logic [HW-1:0] H_VEND  = HW'(H_VIS);
    localparam logic [HW-1:0] HS_BEG  = HW'(H_VIS + H_FP);
    localparam logic [HW-1:0] HS_END  = HW'(H_VIS + H_FP + H_SYNC);
    localparam logic [VW-1:0] V_LAST  = VW'(V_TOT - 1);
    localparam logic [VW-1:0] V_VEND  = VW'(V_VIS);
    localparam logic [VW-1:0] VS_BEG  = VW'(V_VIS + V_FP);
    localparam logic [VW-1:0] VS_END  = VW'(V_VIS + V_FP + V_SYNC);
    localparam logic [SW-1:0] SUB_LAST  = SW'(ROW_SCALE - 1);
    localparam logic [GROW_W-1:0] G_LAST = GROW_W'(FONT_H - 1);

    logic [HW-1:0]        h;
    logic [VW-1:0]        v;
    logic [SW-1:0]        sub;
    logic [BLINK_LOG:0]   frame;

    // Advance the beam; on each new line step the scanline repeat, glyph row and text row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h <= '0; v <= '0; sub <= '0; grow <= '0;
            trow <= '0; row_base <= '0; frame <= '0;
        end else if (h == H_LAST) begin
            h <= '0;
            if (v == V_LAST) begin
                v <= '0; sub <= '0; grow <= '0; trow <= '0; row_base <= '0;
                frame <= frame + 1'b1;
            end else begin
                v <= v + 1'b1;
                if (sub == SUB_LAST) begin
                    sub <= '0;
                    if (grow == G_LAST) begin
                        grow     <= '0;
                        trow     <= trow + 8'd1;
                        row_base <= row_base + ADDR_W'(COLS);
                    end else begin
                        grow <= grow + 1'b1;
                    end
                end else begin
                    sub <= sub + 1'b1;
                end
            end
        end else begin
            h <= h + 1'b1;
        end
    end

    // Decode visibility, sync windows and cell column from the counters.
    always_comb begin
        vis        = (h < H_VEND) && (v < V_VEND);
        hs_n       = !((h >= HS_BEG) && (h < HS_END));
        vs_n       = !((v >= VS_BEG) && (v < VS_END));
        col        = 8'(h >> 3);
        px         = h[2:0];
        blink_show = ~frame[BLINK_LOG];
    end

    a_r2_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (h == H_LAST) |=> (h == '0));
    a_r3_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (h != H_LAST) |=> $stable(v));
    a_r5_row_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (h == H_LAST && sub != SUB_LAST && v != V_LAST) |=> $stable(grow));
endmodule

// File: rtl/txtvga_fetch.sv
// Two-stage fetch: issues the text address for the current position, then
// the font address from the returned code. Assumes both stores answer one
// clock after the address. Tags ride along so pixels meet their glyph bytes.
module txtvga_fetch
    import txtvga_pkg::*;
#(
    parameter int FONT_H = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vis,
    input  logic              hs_n,
    input  logic              vs_n,
    input  logic [7:0]        col,
    input  logic [2:0]        px,
    input  logic [GROW_W-1:0] grow,
    input  logic [7:0]        trow,
    input  logic [ADDR_W-1:0] row_base,
    input  logic              blink_show,
    input  logic              cur_en,
    input  logic              cur_blink,
    input  logic              cur_under,
    input  logic [7:0]        cur_col,
    input  logic [7:0]        cur_row,
    output logic [ADDR_W-1:0] text_addr,
    input  logic [7:0]        text_data,
    output logic [ADDR_W-1:0] font_addr,
    output px_tag_t           tag_out
);
    localparam logic [GROW_W-1:0] G_LAST = GROW_W'(FONT_H - 1);

    px_tag_t tag_s1;
    logic    cur_here;

    // Cursor hit for the current pixel: position, style row and blink phase.
    always_comb begin
        cur_here = cur_en && (col == cur_col) && (trow == cur_row)
                 && (!cur_under || grow == G_LAST)
                 && (!cur_blink || blink_show);
        text_addr = row_base + ADDR_W'(col);
        font_addr = {text_data, tag_s1.grow};
    end

    // Carry the pixel tag through both memory latencies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_s1  <= TAG_IDLE;
            tag_out <= TAG_IDLE;
        end else begin
            tag_s1  <= '{vis: vis, hs_n: hs_n, vs_n: vs_n, px: px,
                         grow: grow, cur: cur_here};
            tag_out <= tag_s1;
        end
    end

    a_r4_glyph_row: assert property (@(posedge clk) disable iff (!rst_n)
        font_addr[GROW_W-1:0] <= G_LAST);
endmodule

// File: rtl/txtvga_shade.sv
// Output stage: selects the glyph bit, applies cursor inversion, the video
// enable and the per-channel gates, and registers pixel and sync lines.
module txtvga_shade
    import txtvga_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  px_tag_t    tag,
    input  logic [7:0] font_data,
    input  logic       video_en,
    input  logic [2:0] rgb_en,
    output logic       red,
    output logic       green,
    output logic       blue,
    output logic       hsync_n,
    output logic       vsync_n
);
    logic lit;

    // Pixel bit for this column, flipped under the cursor, gated by enable and blanking.
    always_comb lit = tag.vis && video_en && (font_data[~tag.px] ^ tag.cur);

    // Register the colour lines and the delayed syncs together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {red, green, blue} <= 3'b000;
            hsync_n <= 1'b1;
            vsync_n <= 1'b1;
        end else begin
            red     <= lit && rgb_en[2];
            green   <= lit && rgb_en[1];
            blue    <= lit && rgb_en[0];
            hsync_n <= tag.hs_n;
            vsync_n <= tag.vs_n;
        end
    end

    a_r6_dark: assert property (@(posedge clk) disable iff (!rst_n)
        !video_en |=> ({red, green, blue} == 3'b000));
    a_r11_blank: assert property (@(posedge clk) disable iff (!rst_n)
        !tag.vis |=> ({red, green, blue} == 3'b000));
    a_r7_red_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !rgb_en[2] |=> !red);
endmodule

// File: rtl/txtvga_render.sv
// Text raster renderer top: raster generator, two-stage fetch and output
// stage. Assumes external text and font stores with one-clock reads.
module txtvga_render
    import txtvga_pkg::*;
#(
    parameter int COLS      = 80,
    parameter int FONT_H    = 10,
    parameter int ROW_SCALE = 2,
    parameter int H_VIS     = 640,
    parameter int H_FP      = 16,
    parameter int H_SYNC    = 96,
    parameter int H_BP      = 48,
    parameter int V_VIS     = 480,
    parameter int V_FP      = 10,
    parameter int V_SYNC    = 2,
    parameter int V_BP      = 33,
    parameter int BLINK_LOG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        ctl,
    input  logic [7:0]        cur_col,
    input  logic [7:0]        cur_row,
    output logic [ADDR_W-1:0] text_addr,
    input  logic [7:0]        text_data,
    output logic [ADDR_W-1:0] font_addr,
    input  logic [7:0]        font_data,
    output logic              red,
    output logic              green,
    output logic              blue,
    output logic              hsync_n,
    output logic              vsync_n
);
    logic              r_vis, r_hs_n, r_vs_n, r_blink;
    logic [7:0]        r_col, r_trow;
    logic [2:0]        r_px;
    logic [GROW_W-1:0] r_grow;
    logic [ADDR_W-1:0] r_base;
    px_tag_t           f_tag;
    logic              unused_ctl;

    assign unused_ctl = ctl[3];

    txtvga_raster #(
        .COLS(COLS), .FONT_H(FONT_H), .ROW_SCALE(ROW_SCALE),
        .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .BLINK_LOG(BLINK_LOG)
    ) u_raster (
        .clk(clk), .rst_n(rst_n), .vis(r_vis), .hs_n(r_hs_n), .vs_n(r_vs_n),
        .col(r_col), .px(r_px), .grow(r_grow), .trow(r_trow),
        .row_base(r_base), .blink_show(r_blink)
    );

    txtvga_fetch #(.FONT_H(FONT_H)) u_fetch (
        .clk(clk), .rst_n(rst_n), .vis(r_vis), .hs_n(r_hs_n), .vs_n(r_vs_n),
        .col(r_col), .px(r_px), .grow(r_grow), .trow(r_trow),
        .row_base(r_base), .blink_show(r_blink),
        .cur_en(ctl[6]), .cur_blink(ctl[5]), .cur_under(ctl[4]),
        .cur_col(cur_col), .cur_row(cur_row),
        .text_addr(text_addr), .text_data(text_data),
        .font_addr(font_addr), .tag_out(f_tag)
    );

    txtvga_shade u_shade (
        .clk(clk), .rst_n(rst_n), .tag(f_tag), .font_data(font_data),
        .video_en(ctl[7]), .rgb_en(ctl[2:0]),
        .red(red), .green(green), .blue(blue),
        .hsync_n(hsync_n), .vsync_n(vsync_n)
    );
endmodule

// File: tb/sim_txtvga_render.sv
`timescale 1ns/1ps
module sim_txtvga_render;
    localparam int COLS = 4, FH = 10;
    localparam int HV = 32, HF = 2, HSY = 3, HB = 2;
    localparam int VV = 20, VF = 1, VSY = 2, VB = 1;
    localparam int HT = HV + HF + HSY + HB;
    localparam int VT = VV + VF + VSY + VB;
    localparam int FRAME = HT * VT;
    localparam int NVEC = 9;

    // {requirement, ctl, cur_col, cur_row, frames}
    localparam logic [39:0] VEC [NVEC] = '{
        {8'd4,  8'b1000_0111, 8'd0, 8'd0, 8'd2},   // R4 plain text, all colours
        {8'd7,  8'b1000_0101, 8'd0, 8'd0, 8'd1},   // R7 red+blue only
        {8'd7,  8'b1000_0010, 8'd0, 8'd0, 8'd1},   // R7 green only
        {8'd6,  8'b0100_0111, 8'd1, 8'd0, 8'd1},   // R6 video off, cursor on
        {8'd8,  8'b1100_0111, 8'd1, 8'd0, 8'd1},   // R8 solid block cursor
        {8'd8,  8'b1100_0110, 8'd3, 8'd1, 8'd1},   // R8 block cursor on row 1
        {8'd9,  8'b1101_0111, 8'd2, 8'd1, 8'd1},   // R9 underline cursor
        {8'd5,  8'b1101_0011, 8'd1, 8'd0, 8'd1},   // R5 scaled rows with underline
        {8'd10, 8'b1110_0111, 8'd0, 8'd0, 8'd34}   // R10 blinking cursor
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ctl = 8'h87, cx = 8'd0, cy = 8'd0;
    logic [11:0] ta0, fa0, ta1, fa1;
    logic [7:0]  td0, fd0, td1, fd1;
    logic        r0, g0, b0, h0, v0, r1, g1, b1, h1, v1;
    int          errors = 0, checks = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] txt_fn(input logic [11:0] a);
        return 8'((int'(a) * 7 + 3) & 255);
    endfunction
    function automatic logic [7:0] font_fn(input logic [11:0] a);
        return 8'(((int'(a) * 37) ^ (int'(a) >> 3)) & 255);
    endfunction

    // External stores with one-clock read latency.
    always @(posedge clk) begin
        td0 <= txt_fn(ta0); fd0 <= font_fn(fa0);
        td1 <= txt_fn(ta1); fd1 <= font_fn(fa1);
    end

    txtvga_render #(.COLS(COLS), .FONT_H(FH), .ROW_SCALE(1),
        .H_VIS(HV), .H_FP(HF), .H_SYNC(HSY), .H_BP(HB),
        .V_VIS(VV), .V_FP(VF), .V_SYNC(VSY), .V_BP(VB), .BLINK_LOG(4)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .cur_col(cx), .cur_row(cy),
        .text_addr(ta0), .text_data(td0), .font_addr(fa0), .font_data(fd0),
        .red(r0), .green(g0), .blue(b0), .hsync_n(h0), .vsync_n(v0));

    txtvga_render #(.COLS(COLS), .FONT_H(FH), .ROW_SCALE(2),
        .H_VIS(HV), .H_FP(HF), .H_SYNC(HSY), .H_BP(HB),
        .V_VIS(VV), .V_FP(VF), .V_SYNC(VSY), .V_BP(VB), .BLINK_LOG(4)) u1 (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .cur_col(cx), .cur_row(cy),
        .text_addr(ta1), .text_data(td1), .font_addr(fa1), .font_data(fd1),
        .red(r1), .green(g1), .blue(b1), .hsync_n(h1), .vsync_n(v1));

    // Expected {vis, r, g, b, hsync_n, vsync_n} for raster position k, row scale s.
    function automatic logic [5:0] expect_px(int k, int s, logic [7:0] c,
                                             logic [7:0] ccol, logic [7:0] crow_r);
        int h, v, f, col, trow, grow, a, bitv;
        logic vis, hs, vs, hit, on;
        logic [7:0] code, fb;
        if (k < 0) return 6'b000011;
        h = k % HT; v = (k / HT) % VT; f = k / FRAME;
        vis = (h < HV) && (v < VV);
        hs = !((h >= HV + HF) && (h < HV + HF + HSY));
        vs = !((v >= VV + VF) && (v < VV + VF + VSY));
        col = h / 8; trow = v / (FH * s); grow = (v / s) % FH;
        a = (trow * COLS + col) % 4096;
        code = txt_fn(12'(a));
        fb = font_fn(12'(int'(code) * 16 + grow));
        bitv = (int'(fb) >> (7 - h % 8)) & 1;
        hit = c[6] && (col == int'(ccol)) && (trow == int'(crow_r))
              && (!c[4] || grow == FH - 1) && (!c[5] || ((f / 16) % 2 == 0));
        on = vis && c[7] && ((bitv != 0) ^ hit);
        return {vis, on && c[2], on && c[1], on && c[0], hs, vs};
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // R1: reset state of both instances.
    task automatic check_reset();
        check({r0, g0, b0, h0, v0} == 5'b00011 && ta0 == 12'd0, "R1", "u0 reset",
              int'({r0, g0, b0, h0, v0, ta0}), int'({5'b00011, 12'd0}));
        check({r1, g1, b1, h1, v1} == 5'b00011 && ta1 == 12'd0, "R1", "u1 reset",
              int'({r1, g1, b1, h1, v1, ta1}), int'({5'b00011, 12'd0}));
    endtask

    task automatic apply_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_reset();
        rst_n = 1'b1;
    endtask

    // Run one table vector and compare every pixel of both instances.
    task automatic run_vec(logic [39:0] vv);
        string req;
        bit bad_h [2], bad_v [2], bad_p [2], bad_b [2];
        int fr;
        logic [5:0] e;
        logic [4:0] a;
        req = $sformatf("R%0d", vv[39:32]);
        ctl = vv[31:24]; cx = vv[23:16]; cy = vv[15:8]; fr = int'(vv[7:0]);
        apply_reset();
        for (int i = 0; i < 2; i++) begin
            bad_h[i] = 0; bad_v[i] = 0; bad_p[i] = 0; bad_b[i] = 0;
        end
        for (int n = 1; n <= fr * FRAME + 3; n++) begin
            @(posedge clk); @(negedge clk);
            for (int i = 0; i < 2; i++) begin
                e = expect_px(n - 3, i + 1, ctl, cx, cy);
                a = (i == 0) ? {r0, g0, b0, h0, v0} : {r1, g1, b1, h1, v1};
                if (a[1] != e[1] && !bad_h[i]) begin
                    bad_h[i] = 1;
                    $display("FAIL R2 u%0d k=%0d hsync actual=%0b expected=%0b", i, n - 3, a[1], e[1]);
                end
                if (a[0] != e[0] && !bad_v[i]) begin
                    bad_v[i] = 1;
                    $display("FAIL R3 u%0d k=%0d vsync actual=%0b expected=%0b", i, n - 3, a[0], e[0]);
                end
                if (a[4:2] != e[4:2]) begin
                    if (e[5] && !bad_p[i]) begin
                        bad_p[i] = 1;
                        $display("FAIL %s u%0d k=%0d rgb actual=%03b expected=%03b", req, i, n - 3, a[4:2], e[4:2]);
                    end else if (!e[5] && !bad_b[i]) begin
                        bad_b[i] = 1;
                        $display("FAIL R11 u%0d k=%0d rgb actual=%03b expected=%03b", i, n - 3, a[4:2], e[4:2]);
                    end
                end
            end
        end
        for (int i = 0; i < 2; i++) begin
            checks += 4;
            errors += int'(bad_h[i]) + int'(bad_v[i]) + int'(bad_p[i]) + int'(bad_b[i]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #4_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        // R1: initial reset.
        repeat (3) @(negedge clk);
        check_reset();
        for (int j = 0; j < NVEC; j++) run_vec(VEC[j]);
        // R4 / R5: text address at position h=9, v=10 (399 clocks after release).
        ctl = 8'h87; cx = 8'd0; cy = 8'd0;
        apply_reset();
        repeat (399) @(posedge clk);
        @(negedge clk);
        check(ta0 == 12'd5, "R4", "u0 text_addr at (9,10)", int'(ta0), 5);
        check(ta1 == 12'd1, "R5", "u1 text_addr at (9,10)", int'(ta1), 1);
        finish_run();
    end
endmodule